// File: doc/BRIEF.md
# Flash status flag generator

This block produces the byte a parallel NOR flash returns on a read while an embedded program or erase operation is in flight. The command decoder and the array sit outside it: the current operation arrives as a mode code, array contents arrive on a data input, and reads arrive as one-cycle strobes. Each strobe also carries a flag that says whether the read address is in a sector selected for erase. When no operation is in flight, and for reads that erase-suspend-read allows, array data passes straight through. Otherwise the output carries a polling bit, two toggle bits, a timeout flag and an erase-window flag.

Two counters stand in for real timing. A busy timer counts cycles of an active program or erase against a programmable limit and raises the timeout flag when that limit is reached. An erase window counter opens on a sector-erase command for a programmable number of cycles, and more commands may join the erase while it is open. A program request that would turn a stored 0 back into a 1 locks the block into a never-ending program. Only reset ends that state.

Top module: `flash_status_gen`

## Requirements
- R1: With mode code 0 (idle) and no lockout, `status_o` equals `array_data_i`.
- R2: When status is returned, bit 7 is the complement of `poll_bit_i`, bits 4, 1 and 0 are 0, and any bits above 7 are 0.
- R3: Bit 6 flips on every read strobe in program (code 1), erase (code 2), erase-suspend-program (code 4) and lockout. It holds in erase-suspend-read (code 3).
- R4: Bit 2 flips on every read strobe with `rd_in_erase_i` high in erase or erase-suspend-read mode. In erase mode it holds on reads outside the erasing sector, and in program mode it always holds.
- R5: In erase-suspend-program mode, a read outside the erasing sector returns bit 2 as 1.
- R6: In erase-suspend-read mode, a read outside the erasing sector returns `array_data_i`.
- R7: Bit 5 reads 1 once program or erase has been active for `tmo_limit_i` cycles. The count holds in suspend modes and clears in idle.
- R8: After an accepted erase command, bit 3 reads 0 for `win_len_i` cycles and then 1. A command while the window is open restarts it. A command after the window has closed is ignored, and idle disarms the window.
- R9: A `prog_cmd_i` pulse where `prog_data_i` has a 1 in a bit that `array_data_i` holds at 0 sets a lockout. While locked, the block behaves as in program mode whatever the mode code is. A program request that only clears bits does not lock.
- R10: Asserting `rst_ni` low clears lockout, toggles, timer and window, and the output returns to array pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Operation code: 0 idle, 1 program, 2 erase, 3 suspend-read, 4 suspend-program |
| rd_i | input | 1 | One-cycle read strobe |
| rd_in_erase_i | input | 1 | Read address lies in a sector selected for erase |
| array_data_i | input | DATA_W | Array contents at the read address |
| poll_bit_i | input | 1 | Bit 7 of the data being written |
| prog_cmd_i | input | 1 | Program request pulse |
| prog_data_i | input | DATA_W | Data of the program request |
| erase_cmd_i | input | 1 | Sector erase command pulse |
| tmo_limit_i | input | TMO_W | Busy cycles before timeout |
| win_len_i | input | WIN_W | Erase window length in cycles |
| status_o | output | DATA_W | Read data or status byte |

## Verification
The bench builds the block with DATA_W=8, TMO_W=8 and WIN_W=4. The narrow window width lets the bench run a full-scale window of 15 cycles, as well as a window restart and an ignored late command, in a handful of reads. A timeout limit of 12 makes the timeout flag rise within one short program phase and again during lockout. A cycle-level model in the bench tracks both toggles, the timer and the window, so every read in every mode is compared.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_PROG    = 3'd1,
    OP_ERASE   = 3'd2,
    OP_SUSP_RD = 3'd3,
    OP_SUSP_PG = 3'd4
  } op_mode_e;

  localparam int unsigned BIT_POLL = 7;
  localparam int unsigned BIT_TOG  = 6;
  localparam int unsigned BIT_TMO  = 5;
  localparam int unsigned BIT_ETMR = 3;
  localparam int unsigned BIT_TOG2 = 2;

endpackage

// File: rtl/fsf_toggle.sv
module fsf_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic en_i,
  output logic q_o
);

  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_q <= 1'b0;
    else if (strobe_i && en_i) q_q <= ~q_q;
  end

  assign q_o = q_q;

  // covers R3 and R4 instances
  p_flip_on_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && en_i) |=> (q_o != $past(q_o)));
  p_hold_no_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_i && en_i) |=> $stable(q_o));

endmodule

// File: rtl/fsf_busy_timer.sv
module fsf_busy_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clear_i)                  cnt_q <= '0;
    else if (run_i && cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= limit_i);

  p_tmo_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !clear_i && $stable(limit_i)) |=> expired_o);
  p_tmo_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clear_i && !expired_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_tmo_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/fsf_erase_window.sv
module fsf_erase_window #(
  parameter int unsigned WIN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_i,
  input  logic             disarm_i,
  input  logic [WIN_W-1:0] len_i,
  output logic             closed_o
);

  logic             armed_q;
  logic [WIN_W-1:0] cnt_q;
  logic             accept;

  // a late command (window already closed) is dropped
  assign accept = cmd_i && (!armed_q || cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (accept) begin
      armed_q <= 1'b1;
      cnt_q   <= len_i;
    end else if (disarm_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign closed_o = armed_q && (cnt_q == '0);

  p_closed_stays_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (closed_o && !disarm_i) |=> closed_o);
  p_win_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !cmd_i && !disarm_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_win_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i && !closed_o) |=> (cnt_q == $past(len_i) && armed_q));

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TMO_W  = 16,
  parameter int unsigned WIN_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              rd_i,
  input  logic              rd_in_erase_i,
  input  logic [DATA_W-1:0] array_data_i,
  input  logic              poll_bit_i,
  input  logic              prog_cmd_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic              erase_cmd_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  input  logic [WIN_W-1:0]  win_len_i,
  output logic [DATA_W-1:0] status_o
);

  logic     lock_q;
  op_mode_e eff_mode;
  logic     busy_run, is_idle, pass_thru, force_tog2;
  logic     tog6_en, tog2_en, tog6, tog2, tmo_flag, etmr_flag;
  logic [DATA_W-1:0] stat_word;

  // raising any cell from 0 to 1 is illegal and locks the algorithm
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else if (prog_cmd_i && |(prog_data_i & ~array_data_i)) lock_q <= 1'b1;
  end

  always_comb begin
    if (lock_q) eff_mode = OP_PROG;
    else begin
      case (mode_i)
        3'd1:    eff_mode = OP_PROG;
        3'd2:    eff_mode = OP_ERASE;
        3'd3:    eff_mode = OP_SUSP_RD;
        3'd4:    eff_mode = OP_SUSP_PG;
        default: eff_mode = OP_IDLE;
      endcase
    end
  end

  always_comb begin
    busy_run   = 1'b0;
    tog6_en    = 1'b0;
    tog2_en    = 1'b0;
    force_tog2 = 1'b0;
    pass_thru  = 1'b0;
    is_idle    = 1'b0;
    case (eff_mode)
      OP_PROG: begin
        busy_run = 1'b1;
        tog6_en  = 1'b1;
      end
      OP_ERASE: begin
        busy_run = 1'b1;
        tog6_en  = 1'b1;
        tog2_en  = rd_in_erase_i;
      end
      OP_SUSP_RD: begin
        tog2_en   = rd_in_erase_i;
        pass_thru = !rd_in_erase_i;
      end
      OP_SUSP_PG: begin
        tog6_en    = 1'b1;
        force_tog2 = !rd_in_erase_i;
      end
      default: begin
        is_idle   = 1'b1;
        pass_thru = 1'b1;
      end
    endcase
  end

  fsf_toggle u_tog6 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (rd_i),
    .en_i     (tog6_en),
    .q_o      (tog6)
  );

  fsf_toggle u_tog2 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (rd_i),
    .en_i     (tog2_en),
    .q_o      (tog2)
  );

  fsf_busy_timer #(.CNT_W(TMO_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy_run),
    .clear_i   (is_idle),
    .limit_i   (tmo_limit_i),
    .expired_o (tmo_flag)
  );

  fsf_erase_window #(.WIN_W(WIN_W)) u_window (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (erase_cmd_i),
    .disarm_i (is_idle),
    .len_i    (win_len_i),
    .closed_o (etmr_flag)
  );

  always_comb begin
    stat_word           = '0;
    stat_word[BIT_POLL] = ~poll_bit_i;
    stat_word[BIT_TOG]  = tog6;
    stat_word[BIT_TMO]  = tmo_flag;
    stat_word[BIT_ETMR] = etmr_flag;
    stat_word[BIT_TOG2] = force_tog2 | tog2;
    status_o = pass_thru ? array_data_i : stat_word;
  end

  p_idle_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd0 && !lock_q) |-> (status_o == array_data_i));
  p_poll_inv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i inside {3'd1, 3'd2, 3'd4}) |-> (status_o[BIT_POLL] == !poll_bit_i));
  p_sp_dq2_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd4 && !lock_q && !rd_in_erase_i) |-> status_o[BIT_TOG2]);
  p_sr_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd3 && !lock_q && !rd_in_erase_i) |-> (status_o == array_data_i));
  p_lock_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
  p_lock_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |-> (status_o[BIT_POLL] == !poll_bit_i));

endmodule

// File: tb/sim_flash_status_gen.sv
module sim_flash_status_gen;

  localparam int DW = 8;
  localparam int TW = 8;
  localparam int WW = 4;
  localparam int LIMIT = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    mode = 3'd0;
  logic          rd = 1'b0;
  logic          in_sec = 1'b0;
  logic [DW-1:0] arr = 8'hA5;
  logic          pbit = 1'b1;
  logic          pcmd = 1'b0;
  logic [DW-1:0] pdata = '0;
  logic          ecmd = 1'b0;
  logic [TW-1:0] limit = TW'(LIMIT);
  logic [WW-1:0] wlen = 4'd6;
  logic [DW-1:0] status;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  // bench model state
  logic m_lock = 0, m_t6 = 0, m_t2 = 0, m_armed = 0;
  int   m_tc = 0, m_wc = 0;

  always #5 clk = ~clk;

  flash_status_gen #(.DATA_W(DW), .TMO_W(TW), .WIN_W(WW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .rd_i(rd), .rd_in_erase_i(in_sec),
    .array_data_i(arr), .poll_bit_i(pbit), .prog_cmd_i(pcmd), .prog_data_i(pdata),
    .erase_cmd_i(ecmd), .tmo_limit_i(limit), .win_len_i(wlen), .status_o(status)
  );

  function automatic logic [2:0] eff();
    if (m_lock) return 3'd1;
    if (mode > 3'd4) return 3'd0;
    return mode;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lock = 0; m_t6 = 0; m_t2 = 0; m_armed = 0; m_tc = 0; m_wc = 0;
    end else begin
      logic [2:0] e;
      e = eff();
      if (rd && (e == 3'd1 || e == 3'd2 || e == 3'd4)) m_t6 = ~m_t6;
      if (rd && in_sec && (e == 3'd2 || e == 3'd3)) m_t2 = ~m_t2;
      if (e == 3'd0) m_tc = 0;
      else if ((e == 3'd1 || e == 3'd2) && m_tc < int'(limit)) m_tc++;
      if (ecmd && (!m_armed || m_wc != 0)) begin m_wc = int'(wlen); m_armed = 1; end
      else if (e == 3'd0) begin m_armed = 0; m_wc = 0; end
      else if (m_wc != 0) m_wc--;
      if (pcmd && |(pdata & ~arr)) m_lock = 1;
    end
  end

  function automatic logic [DW-1:0] expect_byte();
    logic [2:0] e;
    logic [DW-1:0] b;
    e = eff();
    if (e == 3'd0 || (e == 3'd3 && !in_sec)) return arr;
    b = '0;
    b[7] = ~pbit;
    b[6] = m_t6;
    b[5] = (m_tc >= int'(limit));
    b[3] = m_armed && (m_wc == 0);
    b[2] = (e == 3'd4 && !in_sec) ? 1'b1 : m_t2;
    return b;
  endfunction

  task automatic rd_check(input string tag);
    @(negedge clk);
    rd = 1'b1;
    exp_q.push_back(expect_byte());
    tag_q.push_back(tag);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse_erase();
    @(negedge clk); ecmd = 1'b1;
    @(negedge clk); ecmd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare each read against the scoreboard
  initial forever begin
    @(negedge clk);
    #2;
    if (rd) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (status !== e) begin
        errors++;
        $display("FAIL %s: status got %02h expected %02h", t, status, e);
      end
    end
  end

  task automatic direct(input string tag, input logic [DW-1:0] e);
    checks++;
    if (status !== e) begin
      errors++;
      $display("FAIL %s: status got %02h expected %02h", tag, status, e);
    end
  endtask

  logic done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(2);
    direct("R10 reset state", 8'hA5);
    rst_n = 1'b1;
    rd_check("R1 idle pass");
    arr = 8'h3C;
    rd_check("R1 idle pass new data");

    // program: polling, toggle, timeout
    @(negedge clk); mode = 3'd1; pbit = 1'b1;
    rd_check("R2 R3 program read 1");
    rd_check("R3 program read 2");
    pbit = 1'b0;
    rd_check("R2 R3 program read 3");
    wait_cyc(LIMIT);
    rd_check("R7 timeout reached");
    @(negedge clk); mode = 3'd0;
    rd_check("R1 back to idle");
    @(negedge clk); mode = 3'd1;
    rd_check("R7 timer cleared by idle");

    // erase with window
    @(negedge clk); mode = 3'd2; in_sec = 1'b1; pbit = 1'b1; wlen = 4'd6;
    pulse_erase();
    rd_check("R8 window open");
    rd_check("R4 erase in-sector toggle");
    in_sec = 1'b0;
    rd_check("R4 erase out-of-sector hold");
    wait_cyc(6);
    rd_check("R8 window closed");
    pulse_erase();
    rd_check("R8 late command ignored");

    // restart while open
    @(negedge clk); mode = 3'd0;
    @(negedge clk); mode = 3'd2;
    pulse_erase();
    wait_cyc(3);
    pulse_erase();
    wait_cyc(3);
    rd_check("R8 window restarted");
    wait_cyc(6);
    rd_check("R8 restarted window closed");

    // suspend read
    @(negedge clk); mode = 3'd3; in_sec = 1'b1;
    rd_check("R4 suspend-read in-sector toggle");
    rd_check("R3 suspend-read DQ6 held");
    in_sec = 1'b0; arr = 8'h5A;
    rd_check("R6 suspend-read other sector pass");

    // suspend program
    @(negedge clk); mode = 3'd4;
    rd_check("R5 suspend-program DQ2 high");
    in_sec = 1'b1;
    rd_check("R3 suspend-program DQ6 toggles");

    // full-scale window
    @(negedge clk); mode = 3'd0;
    @(negedge clk); mode = 3'd2; wlen = 4'd15;
    pulse_erase();
    wait_cyc(12);
    rd_check("R8 max window still open");
    wait_cyc(3);
    rd_check("R8 max window closed");

    // legal program then lockout
    @(negedge clk); mode = 3'd0; arr = 8'hF0; pdata = 8'h30;
    @(negedge clk); pcmd = 1'b1;
    @(negedge clk); pcmd = 1'b0;
    rd_check("R9 clearing program no lock");
    pdata = 8'h01;
    @(negedge clk); pcmd = 1'b1;
    @(negedge clk); pcmd = 1'b0;
    pbit = 1'b1;
    rd_check("R9 lockout busy in idle mode");
    rd_check("R9 lockout toggles");
    wait_cyc(LIMIT);
    rd_check("R9 R7 lockout timeout");

    // reset clears
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_check("R10 reset clears lockout");

    wait_cyc(3);
    done = 1'b1;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule